// File: doc/BRIEF.md
# Master Protection Context Control Register

This block keeps the access-attribute control word of one bus master and the master's current protection context. The control word holds a default privilege bit and a default security bit, which are used by a master that does not drive its own attributes. It also holds a 2-bit arbitration priority and a permission mask that lists the nonzero contexts software may switch into. A separate 4-bit context register can be changed by software through a write port or by hardware through a load strobe.

Every software write carries the context of the transfer that issued it, `wr_ctx`. A writer in context 0 may set the context register to any value. A writer in any other context may only move to a value whose permission bit is set. Context 0 has no permission bit that can be set, so such a writer can never reach it. Handler-valid flags protect contexts that are reserved for hardware handlers: while a flag is high, a write to the control word stores 0 in the matching permission bit.

Each cycle the context path picks one of four actions. These actions form the block's named decision states. ACT_HOLD applies when there is no request, and the value is kept. ACT_HW applies when the load strobe is high, and the hardware value is taken. ACT_SW_OPEN applies to a software write that is permitted, and the data is taken. ACT_SW_DENY applies to a software write that is refused, and the value is kept. The strobe overrides any software write in the same cycle. A software write goes to ACT_SW_OPEN when the writer is in context 0 or the permission bit is set. Otherwise it goes to ACT_SW_DENY.

Top module: `ctx_ctl_reg`

## Requirements
- R1: After reset, `ctl_rdata` is 0x0000_0303: privileged (bit 0 = 1), non-secure (bit 1 = 1), priority 3 (bits 9:8), all permission bits 0. `pc_o` is 0.
- R2: A control write with `ctl_we` high updates `ctl_rdata` one cycle later. The fields are: bit 0 privilege default (1 = privileged), bit 1 security default (1 = non-secure), bits 9:8 priority, and bits 31:17 the permission bits for contexts 1..15, where bit 16+v belongs to context v. `priv_dflt_o`, `sec_dflt_o` and `prio_o` follow the stored fields.
- R3: Bits 7:2 and 15:10 of `ctl_rdata` read 0, and so does bit 16, the context-0 permission bit. Writes to these bits have no effect.
- R4: On a control write, permission bit 16+v is stored as 0 whenever `hnd_valid[v-1]` is 1, whatever the write data holds.
- R5: A software context write (`pc_we`) from `wr_ctx` = 0 sets `pc_o` to `pc_wdata` one cycle later, for any value.
- R6: A software context write from a nonzero `wr_ctx` that asks for a value v > 0 takes effect only if stored bit 16+v is 1. Otherwise `pc_o` is unchanged.
- R7: A software context write from a nonzero `wr_ctx` that asks for value 0 never changes `pc_o`.
- R8: `hw_pc_load` sets `pc_o` to `hw_pc_value` one cycle later. It ignores the permission bits and wins over a software write in the same cycle.
- R9: With no write strobe, `ctl_rdata` and `pc_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| hnd_valid | input | 15 | Bit v-1 high: handler for context v is valid |
| pc_we | input | 1 | Software context write strobe |
| pc_wdata | input | 4 | Requested context value |
| wr_ctx | input | 4 | Context of the writing transfer |
| hw_pc_load | input | 1 | Hardware context load strobe |
| hw_pc_value | input | 4 | Context value for hardware load |
| pc_o | output | 4 | Current protection context |
| priv_dflt_o | output | 1 | Default privilege attribute |
| sec_dflt_o | output | 1 | Default security attribute (1 = non-secure) |
| prio_o | output | 2 | Arbitration priority (0 highest) |

## Verification
Every stored result is due exactly one clock edge after its strobe, because each field and the context register sit behind a single flop. This applies to control-word fields, permission clearing, permitted or refused context writes, and hardware loads. The bench applies inputs on the falling edge and updates its own model at that point. It then waits one rising edge and compares all outputs on the following falling edge, so every comparison lands one cycle after its stimulus. The permission lookup always uses the mask stored before the edge, and the model does the same when a mask write and a context write share a cycle.

// File: rtl/ctx_ctl_pkg.sv
package ctx_ctl_pkg;
    localparam int CTX_W     = 4;
    localparam int NCTX      = 1 << CTX_W;
    localparam int MASK_W    = NCTX - 1;
    localparam int PRIO_W    = 2;
    localparam int WORD_W    = 32;
    localparam int PRIV_BIT  = 0;
    localparam int SEC_BIT   = 1;
    localparam int PRIO_LSB  = 8;
    localparam int PERM0_BIT = 16;
    localparam int MASK_LSB  = PERM0_BIT + 1;

    localparam logic              RST_PRIV = 1'b1;
    localparam logic              RST_SEC  = 1'b1;
    localparam logic [PRIO_W-1:0] RST_PRIO = '1;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_HW,
        ACT_SW_OPEN,
        ACT_SW_DENY
    } pc_act_e;
endpackage

// File: rtl/ctx_ctl_word.sv
module ctx_ctl_word
    import ctx_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              priv_w,
    input  logic              sec_w,
    input  logic [PRIO_W-1:0] prio_w,
    input  logic [MASK_W-1:0] mask_w,
    input  logic [MASK_W-1:0] hnd_valid,
    output logic              priv_q,
    output logic              sec_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [MASK_W-1:0] mask_q
);
    logic [MASK_W-1:0] mask_d;

    // handler-reserved contexts cannot be opened by a write
    always_comb begin
        mask_d = mask_q;
        if (we) mask_d = mask_w & ~hnd_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_q <= RST_PRIV;
            sec_q  <= RST_SEC;
            prio_q <= RST_PRIO;
            mask_q <= '0;
        end else begin
            if (we) begin
                priv_q <= priv_w;
                sec_q  <= sec_w;
                prio_q <= prio_w;
            end
            mask_q <= mask_d;
        end
    end

    AST_HND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mask_q & $past(hnd_valid)) == '0)); // R4

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(mask_q) && $stable(prio_q) && $stable(priv_q) && $stable(sec_q))); // R9
endmodule

// File: rtl/ctx_pc_guard.sv
module ctx_pc_guard
    import ctx_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask_q,
    input  logic              pc_we,
    input  logic [CTX_W-1:0]  pc_wdata,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic              hw_pc_load,
    input  logic [CTX_W-1:0]  hw_pc_value,
    output logic [CTX_W-1:0]  pc_q
);
    pc_act_e          act;
    logic [NCTX-1:0]  perm;
    logic [CTX_W-1:0] pc_d;

    // context 0 has a permission bit that is always zero
    assign perm = {mask_q, 1'b0};

    always_comb begin
        if (hw_pc_load)
            act = ACT_HW;
        else if (!pc_we)
            act = ACT_HOLD;
        else if ((wr_ctx == '0) || perm[pc_wdata])
            act = ACT_SW_OPEN;
        else
            act = ACT_SW_DENY;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:    pc_d = pc_q;
            ACT_HW:      pc_d = hw_pc_value;
            ACT_SW_OPEN: pc_d = pc_wdata;
            ACT_SW_DENY: pc_d = pc_q;
            default:     pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_pc_load |=> (pc_q == $past(hw_pc_value))); // R8

    AST_CTX0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !hw_pc_load && wr_ctx == '0) |=> (pc_q == $past(pc_wdata))); // R5

    AST_NO_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !hw_pc_load && wr_ctx != '0 && pc_wdata == '0) |=> $stable(pc_q)); // R7

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && !hw_pc_load) |=> $stable(pc_q)); // R9
endmodule

// File: rtl/ctx_ctl_reg.sv
module ctx_ctl_reg
    import ctx_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [WORD_W-1:0]    ctl_wdata,
    output logic [WORD_W-1:0]    ctl_rdata,
    input  logic [MASK_W-1:0]    hnd_valid,
    input  logic                 pc_we,
    input  logic [CTX_W-1:0]     pc_wdata,
    input  logic [CTX_W-1:0]     wr_ctx,
    input  logic                 hw_pc_load,
    input  logic [CTX_W-1:0]     hw_pc_value,
    output logic [CTX_W-1:0]     pc_o,
    output logic                 priv_dflt_o,
    output logic                 sec_dflt_o,
    output logic [PRIO_W-1:0]    prio_o
);
    logic              priv_q, sec_q;
    logic [PRIO_W-1:0] prio_q;
    logic [MASK_W-1:0] mask_q;
    logic              unused_rsv;

    // reserved write bits are dropped on purpose
    assign unused_rsv = ^{ctl_wdata[PRIO_LSB-1:SEC_BIT+1],
                          ctl_wdata[PERM0_BIT:PRIO_LSB+PRIO_W]};

    ctx_ctl_word u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we),
        .priv_w    (ctl_wdata[PRIV_BIT]),
        .sec_w     (ctl_wdata[SEC_BIT]),
        .prio_w    (ctl_wdata[PRIO_LSB +: PRIO_W]),
        .mask_w    (ctl_wdata[MASK_LSB +: MASK_W]),
        .hnd_valid (hnd_valid),
        .priv_q    (priv_q),
        .sec_q     (sec_q),
        .prio_q    (prio_q),
        .mask_q    (mask_q)
    );

    ctx_pc_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_q      (mask_q),
        .pc_we       (pc_we),
        .pc_wdata    (pc_wdata),
        .wr_ctx      (wr_ctx),
        .hw_pc_load  (hw_pc_load),
        .hw_pc_value (hw_pc_value),
        .pc_q        (pc_o)
    );

    always_comb begin
        ctl_rdata                       = '0;
        ctl_rdata[PRIV_BIT]             = priv_q;
        ctl_rdata[SEC_BIT]              = sec_q;
        ctl_rdata[PRIO_LSB +: PRIO_W]   = prio_q;
        ctl_rdata[MASK_LSB +: MASK_W]   = mask_q;
    end

    assign priv_dflt_o = priv_q;
    assign sec_dflt_o  = sec_q;
    assign prio_o      = prio_q;

    AST_CTL_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (prio_o == $past(ctl_wdata[PRIO_LSB +: PRIO_W]) &&
                    priv_dflt_o == $past(ctl_wdata[PRIV_BIT]))); // R2

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_rdata[PERM0_BIT:PRIO_LSB+PRIO_W] == '0 &&
                    ctl_rdata[PRIO_LSB-1:SEC_BIT+1] == '0)); // R3
endmodule

// File: tb/tb_ctx_ctl_reg.sv
module tb_ctx_ctl_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [14:0] hnd_valid = '0;
    logic        pc_we = 1'b0;
    logic [3:0]  pc_wdata = '0;
    logic [3:0]  wr_ctx = '0;
    logic        hw_pc_load = 1'b0;
    logic [3:0]  hw_pc_value = '0;
    logic [3:0]  pc_o;
    logic        priv_dflt_o, sec_dflt_o;
    logic [1:0]  prio_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_priv, m_sec;
    logic [1:0]  m_prio;
    logic [14:0] m_mask;
    logic [3:0]  m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .hnd_valid(hnd_valid), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .wr_ctx(wr_ctx), .hw_pc_load(hw_pc_load),
        .hw_pc_value(hw_pc_value), .pc_o(pc_o), .priv_dflt_o(priv_dflt_o),
        .sec_dflt_o(sec_dflt_o), .prio_o(prio_o)
    );

    function automatic logic [31:0] word_of(logic pv, logic sc, logic [1:0] pr, logic [14:0] mk);
        return {mk, 1'b0, 6'b0, pr, 6'b0, sc, pv};
    endfunction

    function automatic logic pc_allowed(logic [3:0] ctx, logic [3:0] req, logic [14:0] mk);
        if (ctx == 4'd0) return 1'b1;
        if (req == 4'd0) return 1'b0;
        return mk[req - 4'd1];
    endfunction

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk32(req, ctl_rdata, word_of(m_priv, m_sec, m_prio, m_mask));
        chk32(req, {28'd0, pc_o}, {28'd0, m_pc});
        chk32(req, {29'd0, priv_dflt_o, sec_dflt_o, prio_o}, {29'd0, m_priv, m_sec, m_prio});
    endtask

    // apply one cycle of stimulus at the falling edge, update the model, check after the edge
    task automatic cycle(string req, logic cwe, logic [31:0] cwd, logic [14:0] hv,
                         logic pwe, logic [3:0] pwd, logic [3:0] ctx,
                         logic hl, logic [3:0] hval);
        ctl_we = cwe; ctl_wdata = cwd; hnd_valid = hv;
        pc_we = pwe; pc_wdata = pwd; wr_ctx = ctx;
        hw_pc_load = hl; hw_pc_value = hval;
        if (hl) m_pc = hval;
        else if (pwe && pc_allowed(ctx, pwd, m_mask)) m_pc = pwd;
        if (cwe) begin
            m_priv = cwd[0]; m_sec = cwd[1]; m_prio = cwd[9:8];
            m_mask = cwd[31:17] & ~hv;
        end
        @(posedge clk);
        @(negedge clk);
        ctl_we = 1'b0; pc_we = 1'b0; hw_pc_load = 1'b0;
        check_all(req);
    endtask

    initial begin
        m_priv = 1'b1; m_sec = 1'b1; m_prio = 2'd3; m_mask = '0; m_pc = '0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        chk32("R1", ctl_rdata, 32'h0000_0303);

        // R2 R3: all ones, reserved and context-0 bits stay zero
        cycle("R3", 1'b1, 32'hFFFF_FFFF, 15'h0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0);
        chk32("R3", ctl_rdata, 32'hFFFE_0303);
        cycle("R2", 1'b1, 32'h0000_0100, 15'h0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0);
        chk32("R2", ctl_rdata, 32'h0000_0100);
        // R4: handler for context 1 valid clears bit 17
        cycle("R4", 1'b1, 32'hFFFF_FFFF, 15'h0001, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0);
        chk32("R4", ctl_rdata, 32'hFFFC_0303);
        // R6: context 1 closed, context 2 open
        cycle("R6", 1'b0, 32'h0, 15'h0, 1'b1, 4'd1, 4'd5, 1'b0, 4'd0);
        chk32("R6", {28'd0, pc_o}, 32'd0);
        cycle("R6", 1'b0, 32'h0, 15'h0, 1'b1, 4'd2, 4'd5, 1'b0, 4'd0);
        chk32("R6", {28'd0, pc_o}, 32'd2);
        // R7: nonzero writer cannot reach context 0
        cycle("R7", 1'b0, 32'h0, 15'h0, 1'b1, 4'd0, 4'd3, 1'b0, 4'd0);
        chk32("R7", {28'd0, pc_o}, 32'd2);
        // R5: context-0 writer reaches the closed context 1
        cycle("R5", 1'b0, 32'h0, 15'h0, 1'b1, 4'd1, 4'd0, 1'b0, 4'd0);
        chk32("R5", {28'd0, pc_o}, 32'd1);
        // R8: hardware load wins over software in the same cycle
        cycle("R8", 1'b0, 32'h0, 15'h0, 1'b1, 4'd4, 4'd0, 1'b1, 4'd9);
        chk32("R8", {28'd0, pc_o}, 32'd9);
        // R9: idle cycles
        cycle("R9", 1'b0, 32'h1234_5678, 15'h7FFF, 1'b0, 4'd7, 4'd0, 1'b0, 4'd3);

        // random phase, fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            logic cwe, pwe, hl;
            logic [3:0] ctx;
            r   = $urandom;
            cwe = (r[2:0] == 3'd0);
            pwe = r[3] | r[4];
            hl  = (r[9:6] == 4'd0);
            ctx = r[5] ? 4'd0 : 4'($urandom_range(15, 1));
            cycle("R6", cwe, $urandom, 15'($urandom) & 15'($urandom), pwe,
                  4'($urandom), ctx, hl, 4'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule